// File: doc/BRIEF.md
# DMA Protection Range Filter

This block sits in the upstream path of DMA traffic and decides, for every request, whether that request may change memory. It keeps a small, parameterised set of protected windows. Each window has a start register and an end register, and both hold addresses at one-megabyte granularity. A write whose address lies in an active window is blocked. A read always passes. The verdict comes out one cycle after the request is accepted, on a valid/ready output stage.

Software programs the windows through a plain register port. Before it changes a window, software starts a drain handshake. It sets a self-clearing start bit, and a busy flag then stays high until the fabric reports that no non-coherent transactions remain outstanding (`drain_done`). Window registers accept writes only while the handshake is idle, so a window cannot change under traffic that is still draining.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the output stage is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the verdict is held unchanged.

Top module: `dma_guard_filter`

## Requirements
- R1: After reset every window reads as switched off, so a start register reads 0x10 and an end register reads 0. The drain status reads idle, meaning the drain register reads 0, and no request is blocked.
- R2: An accepted write whose address bits [ADDR_W-1:20] fall inside an active window gives `out_block`=1 and `out_allow`=0 on the cycle after acceptance. Any other accepted request gives `out_allow`=1 and `out_block`=0.
- R3: Window bounds are inclusive at both ends. The range test compares only address bits [ADDR_W-1:20], so the low 20 address bits never change the verdict.
- R4: Bit 4 of a start register switches the window off when it is 1 and on when it is 0.
- R5: Reads (`req_write`=0) are never blocked.
- R6: A window whose end field is below its start field matches no address.
- R7: In each start register and end register the window field occupies bits [ADDR_W-1:20]. Bit 3 always reads 0, whatever was written to it. All other bits read 0, except bit 4 of a start register.
- R8: The drain register sits at index 2*RANGES. Writing 1 to its bit 2 sets the busy flag (bit 1) on the next cycle, and bit 2 always reads 0.
- R9: While busy, a cycle with `drain_done`=1 clears the busy flag on the next clock. While idle, `drain_done` has no effect.
- R10: Window register writes that arrive while busy are ignored. Window k's start register sits at index 2k and its end register at index 2k+1.
- R11: While `out_valid` is high and `out_ready` is low, `req_ready` is 0 and the verdict outputs stay stable.
- R12: With several windows active, a write is blocked if any one of them matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Filter can take a request |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Downstream takes the verdict |
| out_allow | output | 1 | Request may proceed |
| out_block | output | 1 | Request must not change memory |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W | Register index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` (combinational) |
| drain_done | input | 1 | Outstanding non-coherent count has reached zero |

## Verification
A window can be rewritten in the same cycle that a request is accepted. The bench provokes this by driving a write request into an active window together with a register write that switches that window off, both on the same edge. The verdict must come from the window as it stood before the edge, so the request is blocked, and the next identical request is allowed. The drain handshake can also coincide with window programming. The bench issues a window write in the same cycle that `drain_done` ends the busy phase, and judges from read-back that the write was dropped because busy was still set at that edge.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int PAGE_LSB   = 20;
  localparam int DIS_BIT    = 4;
  localparam int ACC_BIT    = 3;
  localparam int START_BIT  = 2;
  localparam int BUSY_BIT   = 1;
  localparam int REG_W      = 64;
endpackage

// File: rtl/dgf_range_regs.sv
module dgf_range_regs
  import dgf_pkg::*;
#(
  parameter int RANGES = 4,
  parameter int ADDR_W = 40,
  parameter int IDX_W  = 4,
  localparam int PAGE_W = ADDR_W - PAGE_LSB
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [REG_W-1:0]               wr_data,
  output logic [RANGES-1:0][PAGE_W-1:0]  lo_pg,
  output logic [RANGES-1:0][PAGE_W-1:0]  hi_pg,
  output logic [RANGES-1:0]              off
);
  for (genvar k = 0; k < RANGES; k++) begin : g_win
    localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(2 * k);
    localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(2 * k + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_pg[k] <= '0;
        hi_pg[k] <= '0;
        off[k]   <= 1'b1;
      end else if (wr_en) begin
        if (wr_idx == LO_IDX) begin
          lo_pg[k] <= wr_data[ADDR_W-1:PAGE_LSB];
          off[k]   <= wr_data[DIS_BIT];
        end
        if (wr_idx == HI_IDX) hi_pg[k] <= wr_data[ADDR_W-1:PAGE_LSB];
      end
    end
  end
endmodule

// File: rtl/dgf_range_match.sv
module dgf_range_match
  import dgf_pkg::*;
#(
  parameter int RANGES = 4,
  parameter int ADDR_W = 40,
  localparam int PAGE_W = ADDR_W - PAGE_LSB
) (
  input  logic [PAGE_W-1:0]              page,
  input  logic [RANGES-1:0][PAGE_W-1:0]  lo_pg,
  input  logic [RANGES-1:0][PAGE_W-1:0]  hi_pg,
  input  logic [RANGES-1:0]              off,
  output logic                           any_hit
);
  logic [RANGES-1:0] hit;
  for (genvar k = 0; k < RANGES; k++) begin : g_cmp
    assign hit[k] = !off[k] && (page >= lo_pg[k]) && (page <= hi_pg[k]);
  end
  assign any_hit = |hit;
endmodule

// File: rtl/dgf_drain_ctl.sv
module dgf_drain_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic drain_done,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 busy <= 1'b0;
    else if (!busy && start)    busy <= 1'b1;
    else if (busy && drain_done) busy <= 1'b0;
  end
endmodule

// File: rtl/dma_guard_filter.sv
module dma_guard_filter
  import dgf_pkg::*;
#(
  parameter int RANGES = 4,
  parameter int ADDR_W = 40,
  localparam int PAGE_W = ADDR_W - PAGE_LSB,
  localparam int IDX_W  = $clog2(2 * RANGES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_allow,
  output logic               out_block,
  input  logic               reg_we,
  input  logic [IDX_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               drain_done
);
  localparam logic [IDX_W-1:0] SER_IDX = IDX_W'(2 * RANGES);

  logic [RANGES-1:0][PAGE_W-1:0] lo_pg, hi_pg;
  logic [RANGES-1:0]             off;
  logic                          any_hit;
  logic                          ser_busy;
  logic                          win_we, ser_start;

  assign win_we    = reg_we && !ser_busy && (reg_addr < SER_IDX);
  assign ser_start = reg_we && (reg_addr == SER_IDX) && reg_wdata[START_BIT];

  dgf_range_regs #(.RANGES(RANGES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(win_we), .wr_idx(reg_addr),
    .wr_data(reg_wdata), .lo_pg(lo_pg), .hi_pg(hi_pg), .off(off)
  );

  dgf_range_match #(.RANGES(RANGES), .ADDR_W(ADDR_W)) u_match (
    .page(req_addr[ADDR_W-1:PAGE_LSB]), .lo_pg(lo_pg), .hi_pg(hi_pg),
    .off(off), .any_hit(any_hit)
  );

  dgf_drain_ctl u_drain (
    .clk(clk), .rst_n(rst_n), .start(ser_start),
    .drain_done(drain_done), .busy(ser_busy)
  );

  // verdict stage
  assign req_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_block <= 1'b0;
    end else if (req_ready) begin
      out_valid <= req_valid;
      out_block <= req_valid && req_write && any_hit;
    end
  end
  assign out_allow = out_valid && !out_block;

  // register read-back
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == SER_IDX) begin
      reg_rdata[BUSY_BIT] = ser_busy;
    end else if (reg_addr < SER_IDX) begin
      if (!reg_addr[0]) begin
        reg_rdata[ADDR_W-1:PAGE_LSB] = lo_pg[reg_addr >> 1];
        reg_rdata[DIS_BIT]           = off[reg_addr >> 1];
      end else begin
        reg_rdata[ADDR_W-1:PAGE_LSB] = hi_pg[reg_addr >> 1];
      end
    end
  end
endmodule

// File: rtl/dgf_chk.sv
module dgf_chk #(
  parameter int IDX_W = 4,
  parameter int SER   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_allow,
  input logic             out_block,
  input logic             reg_we,
  input logic [IDX_W-1:0] reg_addr,
  input logic [63:0]      reg_wdata,
  input logic             drain_done,
  input logic             ser_busy
);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_block) && $stable(out_allow));
  // R11
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready);
  // R5
  read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> out_valid && out_allow && !out_block);
  // R8
  drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == IDX_W'(SER) && reg_wdata[2] |=> ser_busy);
  // R9
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_busy && drain_done |=> !ser_busy);
  // R9
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_busy && !reg_we |=> !ser_busy);
endmodule

bind dma_guard_filter dgf_chk #(.IDX_W(IDX_W), .SER(2 * RANGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .out_valid(out_valid), .out_ready(out_ready),
  .out_allow(out_allow), .out_block(out_block), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .drain_done(drain_done),
  .ser_busy(ser_busy)
);

// File: tb/tb_dma_guard_filter.sv
module tb_dma_guard_filter;
  localparam int N  = 4;
  localparam int AW = 40;
  localparam int IW = $clog2(2 * N + 1);
  localparam int SER = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, out_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, out_valid, out_allow, out_block;
  logic reg_we = 1'b0;
  logic [IW-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic drain_done = 1'b0;

  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  longint mlo[N], mhi[N];
  bit     moff[N];

  always #2 clk = ~clk;

  dma_guard_filter #(.RANGES(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .out_valid(out_valid),
    .out_ready(out_ready), .out_allow(out_allow), .out_block(out_block),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .drain_done(drain_done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_block(input longint addr, input bit wr);
    longint pg = addr >> 20;
    bit b = 1'b0;
    for (int r = 0; r < N; r++)
      if (!moff[r] && pg >= mlo[r] && pg <= mhi[r]) b = 1'b1;
    return wr && b;
  endfunction

  task automatic wreg(input int idx, input longint data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = IW'(idx); reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input int idx, output longint v);
    @(negedge clk);
    reg_addr = IW'(idx);
    #1 v = reg_rdata;
  endtask

  // program window k in both the bench model and the design
  task automatic setwin(input int k, input longint lo, input longint hi, input bit of);
    wreg(2 * k, (lo << 20) | (longint'(of) << 4) | 64'h9);
    wreg(2 * k + 1, (hi << 20) | 64'hF);
    mlo[k] = lo; mhi[k] = hi; moff[k] = of;
  endtask

  task automatic send(input longint addr, input bit wr, input string tag);
    bit eb;
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(addr); req_write = wr;
    eb = exp_block(addr, wr);
    @(negedge clk);
    req_valid = 1'b0;
    chk(out_valid && out_block == eb && out_allow == !eb, tag,
        {out_valid, out_block, out_allow}, {1'b1, eb, !eb});
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < 32; p++)
      for (int o = 0; o < 2; o++)
        for (int w = 0; w < 2; w++)
          send((longint'(p) << 20) | (o ? 64'hFFFFF : 64'h0), w[0], tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    longint v;
    for (int r = 0; r < N; r++) begin mlo[r] = 0; mhi[r] = 0; moff[r] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 2 * N; i++) begin
      rreg(i, v);
      chk(v == ((i % 2 == 0) ? 64'h10 : 64'h0), "R1 reset readback", v, (i % 2 == 0) ? 64'h10 : 0);
    end
    rreg(SER, v);
    chk(v == 0, "R1 drain idle", v, 0);
    send(64'h0, 1'b1, "R1 nothing blocked");

    // R7 field layout / bit3 reads 0
    setwin(0, 4, 7, 1'b0);
    rreg(0, v); chk(v == (64'd4 << 20), "R7 start reg", v, 64'd4 << 20);
    rreg(1, v); chk(v == (64'd7 << 20), "R7 end reg", v, 64'd7 << 20);

    // R2 R3 R4 R5 R6 R12 sweep: two active, one inverted, one switched off
    setwin(1, 10, 10, 1'b0);
    setwin(2, 20, 15, 1'b0);
    setwin(3, 25, 28, 1'b1);
    sweep("R2 R3 R5 R6 R12 sweep A");
    // R4 toggle polarity
    setwin(3, 25, 28, 1'b0);
    setwin(0, 4, 7, 1'b1);
    sweep("R4 R12 sweep B");
    // R3 top page boundary
    setwin(2, (64'd1 << 20) - 2, (64'd1 << 20) - 1, 1'b0);
    send(64'hFF_FFFF_FFFF, 1'b1, "R3 top page");
    send(64'hFF_FFD0_0000, 1'b1, "R3 below window");
    send(64'hFF_FFE0_0000, 1'b1, "R3 window start");

    // R8 start drain
    wreg(SER, 64'h4);
    rreg(SER, v); chk(v == 64'h2, "R8 busy set, start bit reads 0", v, 2);
    // R10 window write while busy ignored
    wreg(4, 64'd3 << 20);
    rreg(4, v); chk(v == ((64'd1 << 20) - 2) << 20, "R10 write while busy dropped", v, ((64'd1 << 20) - 2) << 20);
    // R9/R10 window write in the cycle drain_done ends busy
    @(negedge clk);
    drain_done = 1'b1; reg_we = 1'b1; reg_addr = IW'(6); reg_wdata = 64'd2 << 20;
    @(negedge clk);
    drain_done = 1'b0; reg_we = 1'b0;
    rreg(SER, v); chk(v == 0, "R9 busy cleared after drain", v, 0);
    rreg(6, v); chk(v == (64'd25 << 20), "R10 same-edge write dropped", v, 64'd25 << 20);
    // R9 drain_done while idle has no effect
    @(negedge clk); drain_done = 1'b1;
    @(negedge clk); drain_done = 1'b0;
    rreg(SER, v); chk(v == 0, "R9 idle drain ignored", v, 0);
    wreg(SER, 64'h4);
    @(negedge clk); drain_done = 1'b1;
    @(negedge clk); drain_done = 1'b0;
    rreg(SER, v); chk(v == 0, "R9 second drain", v, 0);

    // same-edge: request and window switch-off; old window decides
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(64'd26 << 20); req_write = 1'b1;
    reg_we = 1'b1; reg_addr = IW'(6); reg_wdata = (64'd25 << 20) | 64'h10;
    @(negedge clk);
    req_valid = 1'b0; reg_we = 1'b0;
    chk(out_valid && out_block, "R2 verdict uses old window", out_block, 1);
    moff[3] = 1'b1;
    send(64'd26 << 20, 1'b1, "R4 window now off");

    // R11 back-pressure
    @(negedge clk);
    out_ready = 1'b0; req_valid = 1'b1; req_addr = AW'(64'd10 << 20); req_write = 1'b1;
    @(negedge clk);
    req_addr = AW'(64'd0); req_write = 1'b0;
    chk(out_valid && out_block && !req_ready, "R11 stalled verdict", {out_block, req_ready}, 2'b10);
    repeat (3) @(negedge clk);
    chk(out_valid && out_block && !req_ready, "R11 verdict held", {out_block, req_ready}, 2'b10);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(out_valid && out_allow, "R11 next taken after release", out_allow, 1);
    @(negedge clk);
    chk(!out_valid, "R11 stage empties", out_valid, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule